// File: doc/BRIEF.md
# Detect-Triggered Register Write Replayer

This block stores a short list of register writes and sends them to one peripheral when a voice-detect input rises. Software loads four things: a 32-bit target base address, up to 32 byte-wide address offsets, up to 32 byte-wide data values, and a control word. The control word holds an arm bit and an entry count. The offsets and data values are packed four to a 32-bit register.

When the detect input rises while the block is armed and idle, the block walks the list from the first entry onward. For each entry it issues one write on a valid/ready master port, to the base address plus that entry's offset. It waits for the acknowledge before it moves to the next entry. A busy bit shows that a replay is in progress. A sticky done bit records that the last write was accepted, and software clears it by writing a 1 to it.

A typical use is reconfiguring an analog front end as soon as speech is detected, without waking a processor. A common list of 28 writes fills seven of the eight offset registers and seven of the eight data registers.

Top module: `detect_write_replay`

## Requirements
- R1: After reset the master port shows no valid write, and every readable register reads zero, including busy and done.
- R2: Register indices are: 0 control, 1 status, 2 base, 8 to 15 offset words, 16 to 23 data words. The control word keeps only bit 22 (arm) and bits 19:15 (count); all its other bits read zero. Base, offset and data words read back exactly as written.
- R3: A rising edge on `detect`, seen while armed and idle, raises `wr_valid` at the next clock edge.
- R4: Entry k takes its offset and data from byte k%4 of word k/4, bits 8*(k%4)+7 down to 8*(k%4). Entries are issued in increasing k. Entry k writes `wr_data` = data byte k to `wr_addr` = base + zero-extended offset byte k, with the sum taken modulo 2^32.
- R5: A replay issues exactly count+1 writes, where count is control bits 19:15. This gives 1 to 32 writes.
- R6: Only one write is outstanding at a time. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R7: When control bit 22 is clear, a detect edge produces no write.
- R8: Status bit 0 (busy) reads 1 from the start of a replay until the last write is accepted, and reads 0 after that.
- R9: Status bit 1 (done) is set when the last write is accepted. Writing a 1 there clears it and writing a 0 has no effect. If a clear and a set fall in the same cycle, the set wins.
- R10: A detect edge during a replay is ignored. If detect stays high through the end of a replay, no new replay starts until a fresh rising edge arrives.
- R11: The count is captured when a replay starts. Rewriting the control word during a replay does not change how many writes that replay issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| detect | input | 1 | Voice-detect level; its rising edge starts a replay |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register word index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr`, combinational |
| wr_valid | output | 1 | Master write request |
| wr_ready | input | 1 | Peripheral accepts the current write |
| wr_addr | output | 32 | Master write address |
| wr_data | output | 8 | Master write data |

## Verification
The most delicate case is the one where the acceptance of the final write and a software write-1 to the done bit land on the same clock edge. The bench provokes this by holding the final write pending with ready low. On one falling edge it then raises ready and drives the status clear together, so both take effect at the same rising edge. It then reads status and expects done to be 1, because the set wins. A second pairing, a detect edge arriving while a write is still pending, is judged by counting the accepted writes and checking that the port stays quiet after the replay ends.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam int REG_W   = 32;
  localparam int CTRL_IX = 0;
  localparam int STAT_IX = 1;
  localparam int BASE_IX = 2;
  localparam int OFF_IX  = 8;
  localparam int EN_BIT  = 22;
  localparam int CNT_LSB = 15;

  typedef enum logic {ST_IDLE, ST_RUN} run_st_t;
endpackage

// File: rtl/dwr_regs.sv
module dwr_regs
  import dwr_pkg::*;
#(
  parameter int NW     = 8,
  parameter int IDX_W  = 5,
  parameter int CSR_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_we,
  input  logic [CSR_AW-1:0]    csr_addr,
  input  logic [REG_W-1:0]     csr_wdata,
  output logic [REG_W-1:0]     csr_rdata,
  input  logic                 busy,
  input  logic                 done_set,
  output logic [REG_W-1:0]     base,
  output logic [NW*REG_W-1:0]  off_flat,
  output logic [NW*REG_W-1:0]  dat_flat,
  output logic                 en,
  output logic [IDX_W-1:0]     cnt,
  output logic                 done_flag
);
  localparam int DAT_IX = OFF_IX + NW;

  logic wr_ctrl, wr_stat, wr_base;
  logic done_nxt;

  assign wr_ctrl = csr_we && (csr_addr == CSR_AW'(CTRL_IX));
  assign wr_stat = csr_we && (csr_addr == CSR_AW'(STAT_IX));
  assign wr_base = csr_we && (csr_addr == CSR_AW'(BASE_IX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (wr_ctrl) begin
      en  <= csr_wdata[EN_BIT];
      cnt <= csr_wdata[CNT_LSB +: IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
    end else if (wr_base) begin
      base <= csr_wdata;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic hit_off, hit_dat;
    logic [REG_W-1:0] off_r, dat_r;

    assign hit_off = csr_we && (csr_addr == CSR_AW'(OFF_IX + g));
    assign hit_dat = csr_we && (csr_addr == CSR_AW'(DAT_IX + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_r <= '0;
      end else if (hit_off) begin
        off_r <= csr_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_r <= '0;
      end else if (hit_dat) begin
        dat_r <= csr_wdata;
      end
    end

    assign off_flat[g*REG_W +: REG_W] = off_r;
    assign dat_flat[g*REG_W +: REG_W] = dat_r;
  end

  // set from the sequencer takes priority over a software clear
  always_comb begin
    done_nxt = done_flag;
    if (wr_stat && csr_wdata[1]) done_nxt = 1'b0;
    if (done_set)                done_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
    end else begin
      done_flag <= done_nxt;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == CSR_AW'(CTRL_IX)) begin
      csr_rdata[EN_BIT]              = en;
      csr_rdata[CNT_LSB +: IDX_W]    = cnt;
    end
    if (csr_addr == CSR_AW'(STAT_IX)) begin
      csr_rdata[0] = busy;
      csr_rdata[1] = done_flag;
    end
    if (csr_addr == CSR_AW'(BASE_IX)) csr_rdata = base;
    for (int i = 0; i < NW; i++) begin
      if (csr_addr == CSR_AW'(OFF_IX + i)) csr_rdata = off_flat[i*REG_W +: REG_W];
      if (csr_addr == CSR_AW'(DAT_IX + i)) csr_rdata = dat_flat[i*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/dwr_pick.sv
module dwr_pick
  import dwr_pkg::*;
#(
  parameter int NW    = 8,
  parameter int DW    = 8,
  parameter int IDX_W = 5
) (
  input  logic [NW*REG_W-1:0] flat,
  input  logic [IDX_W-1:0]    idx,
  output logic [DW-1:0]       sel
);
  localparam int NE = NW * (REG_W / DW);

  logic [DW-1:0] ent [NE];

  for (genvar g = 0; g < NE; g++) begin : g_ent
    assign ent[g] = flat[g*DW +: DW];
  end

  assign sel = ent[idx];
endmodule

// File: rtl/dwr_ctl.sv
module dwr_ctl
  import dwr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] cnt_cfg,
  input  logic [AW-1:0]    ent_addr,
  input  logic [DW-1:0]    ent_data,
  output logic [IDX_W-1:0] look_idx,
  input  logic             wr_ready,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             busy,
  output logic             done_set
);
  run_st_t          st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [IDX_W-1:0] last_q, last_n;
  logic [AW-1:0]    addr_n;
  logic [DW-1:0]    data_n;
  logic             ld_out;

  assign busy     = (st_q == ST_RUN);
  assign wr_valid = busy;
  assign look_idx = busy ? idx_q + IDX_W'(1) : '0;

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    last_n   = last_q;
    addr_n   = wr_addr;
    data_n   = wr_data;
    ld_out   = 1'b0;
    done_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n   = ST_RUN;
          idx_n  = '0;
          last_n = cnt_cfg;
          addr_n = ent_addr;
          data_n = ent_data;
          ld_out = 1'b1;
        end
      end
      ST_RUN: begin
        if (wr_ready) begin
          if (idx_q == last_q) begin
            st_n     = ST_IDLE;
            done_set = 1'b1;
          end else begin
            idx_n  = idx_q + IDX_W'(1);
            addr_n = ent_addr;
            data_n = ent_data;
            ld_out = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      last_q <= last_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (ld_out) begin
      wr_addr <= addr_n;
      wr_data <= data_n;
    end
  end
endmodule

// File: rtl/detect_write_replay.sv
module detect_write_replay
  import dwr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 8,
  parameter int N_WORDS = 8,
  parameter int CSR_AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              detect,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int N_ENT = N_WORDS * (REG_W / DATA_W);
  localparam int IDX_W = $clog2(N_ENT);

  logic [1:0]             rst_pipe;
  logic                   rst_n_int;
  logic                   det_q;
  logic                   start;
  logic                   busy;
  logic                   done_set;
  logic                   done_flag;
  logic                   ctrl_en;
  logic [IDX_W-1:0]       ctrl_cnt;
  logic [REG_W-1:0]       base;
  logic [N_WORDS*REG_W-1:0] off_flat, dat_flat;
  logic [IDX_W-1:0]       look_idx;
  logic [DATA_W-1:0]      off_byte, dat_byte;
  logic [ADDR_W-1:0]      ent_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      det_q <= 1'b0;
    end else begin
      det_q <= detect;
    end
  end

  assign start = detect && !det_q && ctrl_en && !busy;

  dwr_regs #(.NW(N_WORDS), .IDX_W(IDX_W), .CSR_AW(CSR_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .busy      (busy),
    .done_set  (done_set),
    .base      (base),
    .off_flat  (off_flat),
    .dat_flat  (dat_flat),
    .en        (ctrl_en),
    .cnt       (ctrl_cnt),
    .done_flag (done_flag)
  );

  dwr_pick #(.NW(N_WORDS), .DW(DATA_W), .IDX_W(IDX_W)) u_pick_off (
    .flat (off_flat),
    .idx  (look_idx),
    .sel  (off_byte)
  );

  dwr_pick #(.NW(N_WORDS), .DW(DATA_W), .IDX_W(IDX_W)) u_pick_dat (
    .flat (dat_flat),
    .idx  (look_idx),
    .sel  (dat_byte)
  );

  assign ent_addr = ADDR_W'(base) + ADDR_W'(off_byte);

  dwr_ctl #(.AW(ADDR_W), .DW(DATA_W), .IDX_W(IDX_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (start),
    .cnt_cfg  (ctrl_cnt),
    .ent_addr (ent_addr),
    .ent_data (dat_byte),
    .look_idx (look_idx),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .done_set (done_set)
  );
endmodule

// File: rtl/detect_write_replay_chk.sv
module detect_write_replay_chk #(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          detect,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          done_flag,
  input logic          ctrl_en
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid); // R6

  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ($stable(wr_addr) && $stable(wr_data))); // R6

  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(ctrl_en)); // R7

  AST_START_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(detect)); // R3

  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_ready) |=> busy); // R8

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(wr_valid && wr_ready)); // R9
endmodule

bind detect_write_replay detect_write_replay_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .detect    (detect),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .busy      (busy),
  .done_flag (done_flag),
  .ctrl_en   (ctrl_en)
);

// File: tb/detect_write_replay_test.sv
`timescale 1ns/1ps
module detect_write_replay_test;
  logic        clk;
  logic        rst_n;
  logic        detect;
  logic        csr_we;
  logic [4:0]  csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        wr_valid;
  logic        wr_ready;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;

  int n_chk;
  int n_bad;
  int hs_cnt;
  int rdy_mode;
  bit fin;

  logic [31:0] m_base;
  logic [7:0]  m_off [32];
  logic [7:0]  m_dat [32];

  bit          pend;
  logic [31:0] pend_addr;
  logic [7:0]  pend_data;

  detect_write_replay uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .detect    (detect),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int k);
    return m_base + {24'h0, m_off[k]};
  endfunction

  function automatic logic [31:0] pack_word(input int w, input bit use_dat);
    logic [31:0] v;
    for (int b = 0; b < 4; b++)
      v[8*b +: 8] = use_dat ? m_dat[4*w+b] : m_off[4*w+b];
    return v;
  endfunction

  // slave model and port monitor
  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      wr_ready = 1'b0;
      pend = 1'b0;
    end else begin
      if (pend && wr_valid) begin
        chk(wr_addr == pend_addr, "R6 addr hold", wr_addr, pend_addr);
        chk(wr_data == pend_data, "R6 data hold", {24'h0, wr_data}, {24'h0, pend_data});
      end
      case (rdy_mode)
        1: wr_ready = 1'b1;
        2: wr_ready = 1'b0;
        default: wr_ready = 1'($urandom % 2);
      endcase
      if (wr_valid && wr_ready) begin
        if (hs_cnt < 32) begin
          chk(wr_addr == exp_addr(hs_cnt), "R4 addr", wr_addr, exp_addr(hs_cnt));
          chk(wr_data == m_dat[hs_cnt], "R4 data", {24'h0, wr_data}, {24'h0, m_dat[hs_cnt]});
        end
        hs_cnt++;
        pend = 1'b0;
      end else if (wr_valid) begin
        pend = 1'b1;
        pend_addr = wr_addr;
        pend_data = wr_data;
      end else begin
        pend = 1'b0;
      end
    end
  end

  task automatic csr_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic set_ctrl(input bit en, input int cnt);
    csr_wr(5'd0, (32'(en) << 22) | (32'(cnt) << 15));
  endtask

  task automatic program_all();
    csr_wr(5'd2, m_base);
    for (int w = 0; w < 8; w++) begin
      csr_wr(5'(8 + w), pack_word(w, 1'b0));
      csr_wr(5'(16 + w), pack_word(w, 1'b1));
    end
  endtask

  task automatic pulse_detect(input bit expect_start);
    @(negedge clk);
    detect = 1'b1;
    @(negedge clk);
    detect = 1'b0;
    if (expect_start) chk(wr_valid == 1'b1, "R3 valid after edge", {31'h0, wr_valid}, 32'h1);
  endtask

  task automatic wait_writes(input int n);
    for (int i = 0; i < 3000 && !(hs_cnt >= n && !wr_valid); i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic run_seq(input int cnt);
    logic [31:0] s;
    hs_cnt = 0;
    pulse_detect(1'b1);
    wait_writes(cnt + 1);
    chk(hs_cnt == cnt + 1, "R5 write count", 32'(hs_cnt), 32'(cnt + 1));
    csr_rd(5'd1, s);
    chk(s[1] == 1'b1, "R9 done set", s, 32'h2);
    chk(s[0] == 1'b0, "R8 idle after end", s, 32'h2);
    csr_wr(5'd1, 32'h2);
  endtask

  task automatic randomize_model();
    m_base = $urandom;
    for (int k = 0; k < 32; k++) begin
      m_off[k] = 8'($urandom);
      m_dat[k] = 8'($urandom);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED1234));
    n_chk = 0; n_bad = 0; hs_cnt = 0; rdy_mode = 0; fin = 1'b0;
    rst_n = 1'b0; detect = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    wr_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(wr_valid == 1'b0, "R1 valid low", {31'h0, wr_valid}, 32'h0);
    csr_rd(5'd0, r);  chk(r == 32'h0, "R1 ctrl", r, 32'h0);
    csr_rd(5'd1, r);  chk(r == 32'h0, "R1 status", r, 32'h0);
    csr_rd(5'd2, r);  chk(r == 32'h0, "R1 base", r, 32'h0);
    csr_rd(5'd13, r); chk(r == 32'h0, "R1 offset word", r, 32'h0);

    // R2 readback
    randomize_model();
    program_all();
    csr_rd(5'd2, r); chk(r == m_base, "R2 base", r, m_base);
    for (int w = 0; w < 8; w++) begin
      csr_rd(5'(8 + w), r);  chk(r == pack_word(w, 1'b0), "R2 offset word", r, pack_word(w, 1'b0));
      csr_rd(5'(16 + w), r); chk(r == pack_word(w, 1'b1), "R2 data word", r, pack_word(w, 1'b1));
    end
    csr_wr(5'd0, 32'hFFFF_FFFF);
    csr_rd(5'd0, r); chk(r == 32'h004F_8000, "R2 ctrl mask", r, 32'h004F_8000);

    // R4 R5 random lists with random ready
    for (int it = 0; it < 6; it++) begin
      int c;
      randomize_model();
      c = int'($urandom % 32);
      program_all();
      set_ctrl(1'b1, c);
      rdy_mode = 0;
      run_seq(c);
    end

    // R4 R5 directed: shortest, typical, longest, address wrap
    rdy_mode = 1;
    randomize_model();
    m_base = 32'hFFFF_FFF0;
    m_off[0] = 8'hFF;
    program_all();
    set_ctrl(1'b1, 0);  run_seq(0);
    set_ctrl(1'b1, 27); run_seq(27);
    set_ctrl(1'b1, 31); run_seq(31);

    // R7 disarmed
    set_ctrl(1'b0, 5);
    hs_cnt = 0;
    pulse_detect(1'b0);
    repeat (30) @(negedge clk);
    chk(hs_cnt == 0, "R7 no writes when disarmed", 32'(hs_cnt), 32'h0);
    chk(wr_valid == 1'b0, "R7 valid low", {31'h0, wr_valid}, 32'h0);

    // R8 busy, R10 detect while busy
    set_ctrl(1'b1, 7);
    rdy_mode = 2;
    hs_cnt = 0;
    pulse_detect(1'b1);
    csr_rd(5'd1, r); chk(r[0] == 1'b1, "R8 busy during replay", r, 32'h1);
    pulse_detect(1'b0);
    rdy_mode = 1;
    wait_writes(8);
    repeat (20) @(negedge clk);
    chk(hs_cnt == 8, "R10 edge while busy ignored", 32'(hs_cnt), 32'h8);
    chk(wr_valid == 1'b0, "R10 no restart", {31'h0, wr_valid}, 32'h0);
    csr_wr(5'd1, 32'h2);

    // R10 detect held across completion
    rdy_mode = 0;
    set_ctrl(1'b1, 3);
    hs_cnt = 0;
    @(negedge clk);
    detect = 1'b1;
    wait_writes(4);
    repeat (20) @(negedge clk);
    chk(hs_cnt == 4, "R10 held detect no restart", 32'(hs_cnt), 32'h4);
    detect = 1'b0;
    csr_wr(5'd1, 32'h2);

    // R11 count captured at start
    rdy_mode = 2;
    set_ctrl(1'b1, 3);
    hs_cnt = 0;
    pulse_detect(1'b1);
    set_ctrl(1'b1, 31);
    rdy_mode = 1;
    wait_writes(4);
    chk(hs_cnt == 4, "R11 count snapshot", 32'(hs_cnt), 32'h4);
    csr_wr(5'd1, 32'h2);

    // R9 clear and set on the same edge
    csr_rd(5'd1, r); chk(r[1] == 1'b0, "R9 done cleared", r, 32'h0);
    rdy_mode = 2;
    set_ctrl(1'b1, 0);
    hs_cnt = 0;
    pulse_detect(1'b1);
    repeat (2) @(negedge clk);
    @(negedge clk);
    rdy_mode = 1;
    csr_we = 1'b1; csr_addr = 5'd1; csr_wdata = 32'h2;
    @(negedge clk);
    csr_we = 1'b0;
    rdy_mode = 2;
    chk(hs_cnt == 1, "R9 final write taken", 32'(hs_cnt), 32'h1);
    csr_rd(5'd1, r); chk(r[1] == 1'b1, "R9 set beats clear", r, 32'h2);
    csr_wr(5'd1, 32'h0);
    csr_rd(5'd1, r); chk(r[1] == 1'b1, "R9 write zero keeps", r, 32'h2);
    csr_wr(5'd1, 32'h2);
    csr_rd(5'd1, r); chk(r[1] == 1'b0, "R9 write one clears", r, 32'h0);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule